// File: doc/BRIEF.md
# Sequential Integer Divider

A multi-cycle divider that divides a double-width dividend by a single-width divisor. The dividend arrives as two halves, `hi_i` (upper) and `lo_i` (lower). The result goes back in the same split form: the quotient replaces the low half on `lo_o` and the remainder replaces the high half on `hi_o`. The divisor width `W` is a parameter, so one source covers the byte form (16-bit dividend) and the word form (32-bit dividend).

A two-bit operation code selects one of three functions:

- unsigned division;
- signed division, which truncates toward zero and gives the remainder the dividend's sign;
- a sign-extension operation, which builds the high half from the sign bit of the low half.

A single-cycle `start_i` pulse launches an operation. `busy_o` stays high while a division runs, and `done_o` pulses for one cycle when the results are ready. A zero divisor, or a quotient that does not fit in `W` bits under the chosen signedness, raises `err_o`. In that case the result outputs keep their previous contents.

The division engine is a restoring shift-subtract loop that resolves one quotient bit per clock over all `2*W` dividend bits. Signed division runs on magnitudes and fixes the signs afterwards.

Top module: `int_divider`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o`, `hi_o` and `lo_o` are all zero.
- R2: With `op_i` = 2'b00 (unsigned divide), `lo_o` is the unsigned quotient of {`hi_i`,`lo_i`} / `dvsr_i` and `hi_o` is the remainder. For W=8, 0083h/02h gives lo 41h, hi 01h. For W=16, 00008003h/0100h gives lo 0080h, hi 0003h.
- R3: With `op_i` = 2'b01 (signed divide), the operands are two's complement, the quotient truncates toward zero and the remainder carries the dividend's sign. For W=8, FFD0h/05h (-48/5) gives lo F7h (-9), hi FDh (-3). 0007h/FEh (7/-2) gives lo FDh (-3), hi 01h.
- R4: A zero `dvsr_i` in either divide mode sets `err_o` and leaves `hi_o`/`lo_o` unchanged.
- R5: A quotient outside W bits sets `err_o` and leaves `hi_o`/`lo_o` unchanged. The unsigned range is 0..2^W-1 (for W=8, 0200h/02h errs and 01FEh/02h gives FFh). The signed range is -2^(W-1)..2^(W-1)-1 (for W=8, 0080h/01h errs and FF80h/01h gives lo 80h, hi 00h).
- R6: With `op_i[1]` = 1 (sign extend), `hi_o` becomes W copies of `lo_i[W-1]`, `lo_o` becomes `lo_i`, and `err_o` clears. `hi_i` and `dvsr_i` are ignored. For W=8, 9Bh gives FF9Bh.
- R7: `done_o` is high for one cycle. For a division with a nonzero divisor it begins 2W+1 rising edges after the edge that accepted `start_i`. For sign extension or a zero divisor it begins at the accepting edge itself.
- R8: `busy_o` is high from the accepting edge of a division until `done_o` rises, and is low while `done_o` is high. `start_i` is ignored while `busy_o` is high.
- R9: `hi_o`, `lo_o` and `err_o` change only in a `done_o` cycle. A later successful operation clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (taken only when idle) |
| op_i | input | 2 | Bit 1: sign extend; else bit 0: 1 signed, 0 unsigned divide |
| hi_i | input | W | Upper half of dividend |
| lo_i | input | W | Lower half of dividend |
| dvsr_i | input | W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide error flag of the last completed operation |
| hi_o | output | W | Remainder, or sign fill in extend mode |
| lo_o | output | W | Quotient, or copy of `lo_i` in extend mode |

## Verification
Some properties hold on every cycle and are checked continuously:

- the result outputs hold outside a completion cycle and also hold through an erroring completion;
- `busy_o` is low during `done_o`;
- every completion arrives either at once or after exactly 2W+1 busy cycles.

Other behaviour can only be shown by the directed scenarios:

- the arithmetic of the results, including the rounding direction, the remainder sign, the exact overflow boundaries in both signednesses, and the sign fill;
- a start pulse issued during a running division having no effect.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  localparam int OP_EXT_BIT = 1;
  localparam int OP_SGN_BIT = 0;
endpackage

// File: rtl/div_prep.sv
// Operand conditioning: magnitudes and result sign decisions
module div_prep #(
  parameter int W = 8
) (
  input  logic            is_signed_i,
  input  logic [W-1:0]    hi_i,
  input  logic [W-1:0]    lo_i,
  input  logic [W-1:0]    dvsr_i,
  output logic [2*W-1:0]  dvd_mag_o,
  output logic [W-1:0]    dvs_mag_o,
  output logic            neg_q_o,
  output logic            neg_r_o,
  output logic            dvs_zero_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dvd;
  logic          dvd_neg, dvs_neg;

  assign dvd        = {hi_i, lo_i};
  assign dvd_neg    = is_signed_i & dvd[DW-1];
  assign dvs_neg    = is_signed_i & dvsr_i[W-1];
  assign dvd_mag_o  = dvd_neg ? (~dvd + {{(DW-1){1'b0}}, 1'b1}) : dvd;
  assign dvs_mag_o  = dvs_neg ? (~dvsr_i + {{(W-1){1'b0}}, 1'b1}) : dvsr_i;
  assign neg_q_o    = dvd_neg ^ dvs_neg;
  assign neg_r_o    = dvd_neg;
  assign dvs_zero_o = (dvsr_i == '0);
endmodule

// File: rtl/div_core.sv
// Restoring shift-subtract engine, one quotient bit per step
module div_core #(
  parameter int W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [2*W-1:0]  dvd_i,
  input  logic [W-1:0]    dvs_i,
  output logic [2*W-1:0]  quo_o,
  output logic [W-1:0]    rem_o
);
  localparam int DW = 2 * W;

  logic [DW-1:0] quo_q;
  logic [W-1:0]  rem_q, dvs_q;
  logic [W:0]    shifted, trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[DW-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = (shifted >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      quo_q <= dvd_i;
      rem_q <= '0;
      dvs_q <= dvs_i;
    end else if (step_i) begin
      quo_q <= {quo_q[DW-2:0], fits};
      rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/div_fix.sv
// Sign restoration and range check of the raw quotient
module div_fix #(
  parameter int W = 8
) (
  input  logic            is_signed_i,
  input  logic            neg_q_i,
  input  logic            neg_r_i,
  input  logic [2*W-1:0]  quo_mag_i,
  input  logic [W-1:0]    rem_mag_i,
  output logic [W-1:0]    quo_o,
  output logic [W-1:0]    rem_o,
  output logic            ovf_o
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [DW-1:0] NEG_LIM = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};

  logic [W-1:0] q_lo;

  assign q_lo = quo_mag_i[W-1:0];

  always_comb begin
    if (!is_signed_i) begin
      ovf_o = |quo_mag_i[DW-1:W];
      quo_o = q_lo;
      rem_o = rem_mag_i;
    end else begin
      ovf_o = neg_q_i ? (quo_mag_i > NEG_LIM) : (quo_mag_i > POS_LIM);
      quo_o = neg_q_i ? (~q_lo + {{(W-1){1'b0}}, 1'b1}) : q_lo;
      rem_o = neg_r_i ? (~rem_mag_i + {{(W-1){1'b0}}, 1'b1}) : rem_mag_i;
    end
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [W-1:0]  hi_i,
  input  logic [W-1:0]  lo_i,
  input  logic [W-1:0]  dvsr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [W-1:0]  hi_o,
  output logic [W-1:0]  lo_o
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          sgn_q, neg_q_q, neg_r_q;
  logic          done_q, err_q;
  logic [W-1:0]  hi_q, lo_q;

  logic          accept, is_ext, load, step;
  logic [DW-1:0] dvd_mag, quo_raw;
  logic [W-1:0]  dvs_mag, rem_raw, q_fix, r_fix;
  logic          neg_q_c, neg_r_c, dvs_zero, ovf;

  assign is_ext = op_i[OP_EXT_BIT];
  assign accept = start_i && (state_q == ST_IDLE);
  assign load   = accept && !is_ext && !dvs_zero;
  assign step   = (state_q == ST_RUN);

  div_prep #(.W(W)) u_prep (
    .is_signed_i (op_i[OP_SGN_BIT]),
    .hi_i        (hi_i),
    .lo_i        (lo_i),
    .dvsr_i      (dvsr_i),
    .dvd_mag_o   (dvd_mag),
    .dvs_mag_o   (dvs_mag),
    .neg_q_o     (neg_q_c),
    .neg_r_o     (neg_r_c),
    .dvs_zero_o  (dvs_zero)
  );

  div_core #(.W(W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .quo_o  (quo_raw),
    .rem_o  (rem_raw)
  );

  div_fix #(.W(W)) u_fix (
    .is_signed_i (sgn_q),
    .neg_q_i     (neg_q_q),
    .neg_r_i     (neg_r_q),
    .quo_mag_i   (quo_raw),
    .rem_mag_i   (rem_raw),
    .quo_o       (q_fix),
    .rem_o       (r_fix),
    .ovf_o       (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sgn_q   <= 1'b0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (is_ext) begin
              hi_q   <= {W{lo_i[W-1]}};
              lo_q   <= lo_i;
              err_q  <= 1'b0;
              done_q <= 1'b1;
            end else if (dvs_zero) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              cnt_q   <= '0;
              sgn_q   <= op_i[OP_SGN_BIT];
              neg_q_q <= neg_q_c;
              neg_r_q <= neg_r_c;
            end
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          if (ovf) begin
            err_q <= 1'b1;
          end else begin
            hi_q  <= r_fix;
            lo_q  <= q_fix;
            err_q <= 1'b0;
          end
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         busy_o,
  input logic         done_o,
  input logic         err_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int RCW = $clog2(2 * W + 2) + 1;
  localparam logic [RCW-1:0] LONG_RUN = RCW'(2 * W + 1);

  logic [RCW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= '0;
    else         run_cnt <= busy_o ? run_cnt + 1'b1 : '0;
  end

  // R8
  busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hi_o) && $stable(lo_o) && $stable(err_o)));

  // R4
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> ($stable(hi_o) && $stable(lo_o)));

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == '0 || run_cnt == LONG_RUN));
endmodule

bind int_divider int_divider_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o),
  .hi_o   (hi_o),
  .lo_o   (lo_o)
);

// File: tb/int_divider_tb.sv
module int_divider_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       start8 = 1'b0;
  logic [1:0] op8 = 2'b00;
  logic [7:0] hi8 = '0, lo8 = '0, d8 = '0;
  logic       busy8, done8, err8;
  logic [7:0] hio8, loo8;

  logic        start16 = 1'b0;
  logic [1:0]  op16 = 2'b00;
  logic [15:0] hi16 = '0, lo16 = '0, d16 = '0;
  logic        busy16, done16, err16;
  logic [15:0] hio16, loo16;

  int checks = 0;
  int fails  = 0;

  int_divider #(.W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start8), .op_i(op8),
    .hi_i(hi8), .lo_i(lo8), .dvsr_i(d8),
    .busy_o(busy8), .done_o(done8), .err_o(err8), .hi_o(hio8), .lo_o(loo8)
  );

  int_divider #(.W(16)) u_dut_w16 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start16), .op_i(op16),
    .hi_i(hi16), .lo_i(lo16), .dvsr_i(d16),
    .busy_o(busy16), .done_o(done16), .err_o(err16), .hi_o(hio16), .lo_o(loo16)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // lat = rising edges from the accepting edge to the start of the done cycle
  task automatic run8(input logic [1:0] op, input logic [7:0] h, input logic [7:0] l,
                      input logic [7:0] d, output int lat);
    @(negedge clk);
    op8 = op; hi8 = h; lo8 = l; d8 = d; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    lat = 0;
    while (!done8 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy8, 0);
    chk("R1 done", done8, 0);
    chk("R1 err", err8, 0);
    chk("R1 hi", hio8, 0);
    chk("R1 lo", loo8, 0);
  endtask

  task automatic t_unsigned;
    int lat;
    run8(2'b00, 8'h00, 8'h83, 8'h02, lat);
    chk("R2 quotient", loo8, 8'h41);
    chk("R2 remainder", hio8, 8'h01);
    chk("R2 err", err8, 0);
    chk("R7 long latency", lat, 17);
    @(negedge clk);
    chk("R7 done one cycle", done8, 0);
  endtask

  task automatic t_sext;
    int lat;
    run8(2'b10, 8'h12, 8'h9B, 8'h00, lat);
    chk("R6 fill ones", hio8, 8'hFF);
    chk("R6 low kept", loo8, 8'h9B);
    chk("R7 short latency", lat, 0);
    run8(2'b11, 8'hAA, 8'h45, 8'h07, lat);
    chk("R6 fill zeros", hio8, 8'h00);
    chk("R6 low kept 2", loo8, 8'h45);
    chk("R6 err", err8, 0);
  endtask

  task automatic t_signed;
    int lat;
    run8(2'b01, 8'hFF, 8'hD0, 8'h05, lat);
    chk("R3 -48/5 quotient", loo8, 8'hF7);
    chk("R3 -48/5 remainder", hio8, 8'hFD);
    chk("R3 err", err8, 0);
    run8(2'b01, 8'h00, 8'h07, 8'hFE, lat);
    chk("R3 7/-2 quotient", loo8, 8'hFD);
    chk("R3 7/-2 remainder", hio8, 8'h01);
  endtask

  task automatic t_zero_div;
    int lat;
    run8(2'b00, 8'h00, 8'h83, 8'h02, lat);
    run8(2'b01, 8'h12, 8'h34, 8'h00, lat);
    chk("R4 err", err8, 1);
    chk("R4 hi held", hio8, 8'h01);
    chk("R4 lo held", loo8, 8'h41);
    chk("R7 zero div latency", lat, 0);
    repeat (3) @(negedge clk);
    chk("R9 err sticks", err8, 1);
    run8(2'b00, 8'h01, 8'hFE, 8'h02, lat);
    chk("R9 err cleared", err8, 0);
    chk("R5 unsigned max quotient", loo8, 8'hFF);
    chk("R5 unsigned max remainder", hio8, 8'h00);
  endtask

  task automatic t_overflow;
    int lat;
    run8(2'b00, 8'h02, 8'h00, 8'h02, lat);
    chk("R5 unsigned ovf err", err8, 1);
    chk("R5 unsigned ovf lo held", loo8, 8'hFF);
    chk("R5 unsigned ovf hi held", hio8, 8'h00);
    run8(2'b01, 8'hFF, 8'h80, 8'h01, lat);
    chk("R5 signed min ok", err8, 0);
    chk("R5 signed min quotient", loo8, 8'h80);
    chk("R5 signed min remainder", hio8, 8'h00);
    run8(2'b01, 8'h00, 8'h80, 8'h01, lat);
    chk("R5 signed ovf err", err8, 1);
    chk("R5 signed ovf lo held", loo8, 8'h80);
  endtask

  task automatic t_busy_ignore;
    int lat;
    @(negedge clk);
    op8 = 2'b00; hi8 = 8'h00; lo8 = 8'h83; d8 = 8'h02; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    chk("R8 busy after accept", busy8, 1);
    @(negedge clk);
    op8 = 2'b10; lo8 = 8'h9B; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    lat = 2;
    while (!done8 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 ignored start latency", lat, 17);
    chk("R8 busy low at done", busy8, 0);
    chk("R8 first op quotient", loo8, 8'h41);
    chk("R8 first op remainder", hio8, 8'h01);
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done8) lat++;
    end
    chk("R8 no second completion", lat, 0);
  endtask

  task automatic t_word;
    int lat;
    @(negedge clk);
    op16 = 2'b00; hi16 = 16'h0000; lo16 = 16'h8003; d16 = 16'h0100; start16 = 1'b1;
    @(negedge clk);
    start16 = 1'b0;
    lat = 0;
    while (!done16 && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R2 w16 quotient", loo16, 16'h0080);
    chk("R2 w16 remainder", hio16, 16'h0003);
    chk("R7 w16 latency", lat, 33);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unsigned();
    t_sext();
    t_signed();
    t_zero_div();
    t_overflow();
    t_busy_ignore();
    t_word();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule